// File: doc/BRIEF.md
# Special-Register Console Port

This block is a one-byte-each-way character channel between a processor core and whatever sits at the far end (a host tool, a simple display, or nothing at all). The core reaches it through two special-register addresses instead of memory. One address holds a two-bit status word. The other address is shared by both directions: a core read returns the byte that has arrived from the host, and a core write loads the byte that is going out to the host.

Each direction has exactly one byte of storage and one handshake flag, and the hardware moves that flag by itself. The flags are bit 0, "a received byte waits for the core", and bit 1, "the outgoing byte has not yet been taken". A core write sets bit 1 and a host take clears it. A host delivery sets bit 0 and a core read of the data address clears it. Both flags can be seen from the core through the status register and from the host on a dedicated flag output.

On the host side both directions are valid/ready streams. The outgoing stream presents `out_valid` (equal to bit 1) and `out_byte`, and the transfer completes in any cycle where `out_valid` and `out_ready` are both high. `out_valid` stays high and `out_byte` stays stable until that happens, so the host can apply back-pressure for as long as it likes. The incoming stream accepts `in_byte` in any cycle where `in_valid` and `in_ready` are both high. `in_ready` is high when bit 0 is clear, or when the core is reading the data address in that same cycle. A delivery offered while `in_ready` is low is simply not accepted, and the host must hold it. If the host side is left unconnected, the core side still behaves correctly: the transmit flag stays set after the first write, and the receive flag never rises.

Top module: `cons_sr_port`

## Requirements
- R1: After reset, both flags are 0, `out_valid` is 0, `out_byte` is 0, the receive buffer is 0, and a core read of the data address returns 0.
- R2: A core read of the status address (`core_sel` = 0) returns bit 0 = receive flag, bit 1 = transmit flag, and bits 7..2 = 0, all in the same cycle. `host_flags` carries the same two bits at the same positions.
- R3: A core write to the data address (`core_sel` = 1) while bit 1 is 0 loads `core_wdata` into `out_byte`. It also sets bit 1 and `out_valid` from the next cycle on.
- R4: A core write to the data address while bit 1 is 1 is ignored: `out_byte` and the flag keep their values.
- R5: While bit 1 is 1, a cycle with `out_ready` high clears bit 1 and `out_valid` from the next cycle on. While bit 1 is 0, `out_ready` has no effect.
- R6: `in_ready` is high when bit 0 is 0, or when the core reads the data address in the same cycle. An accepted delivery latches `in_byte` and sets bit 0 from the next cycle on.
- R7: A delivery offered while bit 0 is 1, with no core data read in that cycle, is ignored. The unread byte and the flag are preserved.
- R8: A core read of the data address returns the receive buffer in the same cycle. If no delivery is accepted in that cycle, bit 0 is 0 from the next cycle on.
- R9: When a core data read and a host delivery happen in the same cycle, the read returns the old byte, the new byte is latched, and bit 0 stays 1.
- R10: A core write to the status address has no effect on any state. A read of any address other than 0 or 1, or any cycle with `core_rd` low, returns 0 on `core_rdata`.
- R11: Over any mix of transfers, every byte accepted in each direction is delivered exactly once and in order. No byte is lost and none is duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_sel | input | SEL_W (2) | Special-register select: 0 status, 1 data |
| core_rd | input | 1 | Core read strobe |
| core_wr | input | 1 | Core write strobe |
| core_wdata | input | DATA_W (8) | Core write data |
| core_rdata | output | DATA_W (8) | Core read data, combinational |
| out_byte | output | DATA_W (8) | Byte toward the host |
| out_valid | output | 1 | Outgoing byte present (transmit flag) |
| out_ready | input | 1 | Host takes the outgoing byte |
| in_byte | input | DATA_W (8) | Byte from the host |
| in_valid | input | 1 | Host offers an incoming byte |
| in_ready | output | 1 | Port can accept the incoming byte |
| host_flags | output | 2 | Bit 0 receive flag, bit 1 transmit flag |

## Verification
Directed sequences drive each flag through its full set of transitions:
- a write into an empty transmit slot, and a write into a full one;
- a host take, and a take with nothing pending;
- a delivery into an empty receive slot, and a delivery into a full one;
- a read on its own, and a read in the same cycle as a delivery;
- writes to the status address, and reads of unused addresses.

These cases tell an accepted action apart from an ignored one, and they separate the case where the delivery wins from the case where the read clears the flag. A long random run then mixes back-to-back traffic in both directions, including stretches where the host stays silent. Every cycle is compared against a behavioural model, and a byte scoreboard catches any byte that is dropped, repeated or reordered.

// File: rtl/cons_port_pkg.sv
package cons_port_pkg;
  localparam int unsigned FLAG_W      = 2;
  localparam int unsigned RX_FLAG_BIT = 0;
  localparam int unsigned TX_FLAG_BIT = 1;

  // Packed so that tx_busy lands on bit 1 and rx_full on bit 0.
  typedef struct packed {
    logic tx_busy;
    logic rx_full;
  } cons_flags_t;
endpackage

// File: rtl/cons_rx_slot.sv
// One-byte receive slot: the host fills it, a core data read drains it.
module cons_rx_slot #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_byte,
  output logic              in_ready,
  input  logic              drain,
  output logic              full,
  output logic [DATA_W-1:0] held
);
  logic accept;

  // A drain in this same cycle frees the slot, so the delivery can land.
  assign in_ready = !full || drain;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      held <= '0;
    end else if (accept) begin
      full <= 1'b1;
      held <= in_byte;
    end else if (drain) begin
      full <= 1'b0;
    end
  end

  // R6: a delivery into an empty slot is latched.
  a_r6_latch_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && in_valid) |=> (full && held == $past(in_byte)));

  // R7: a delivery into a full slot with no drain leaves the byte alone.
  a_r7_keep_unread: assert property (@(posedge clk) disable iff (!rst_n)
    (full && in_valid && !drain) |=> (full && $stable(held)));

  // R8: a drain with no delivery empties the slot.
  a_r8_drain_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && !in_valid) |=> !full);

  // R9: a delivery in the same cycle as a drain wins.
  a_r9_delivery_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (full && drain && in_valid) |=> (full && held == $past(in_byte)));
endmodule

// File: rtl/cons_tx_slot.sv
// One-byte transmit slot: a core write fills it, a host take drains it.
module cons_tx_slot #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              out_take,
  output logic              busy,
  output logic [DATA_W-1:0] held
);
  logic accept;

  // Writes are only taken into an empty slot.
  assign accept = wr_req && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      held <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      held <= wr_byte;
    end else if (out_take) begin
      busy <= 1'b0;
    end
  end

  // R3: a write into an empty slot loads the byte and raises the flag.
  a_r3_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !busy) |=> (busy && held == $past(wr_byte)));

  // R4: while the slot is occupied, the byte cannot change.
  a_r4_busy_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(held));

  // R5: a take of an occupied slot clears the flag.
  a_r5_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && out_take) |=> !busy);
endmodule

// File: rtl/cons_reg_decode.sv
// Special-register decode and read-data multiplexing.
module cons_reg_decode
  import cons_port_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned STAT_SEL = 0,
  parameter int unsigned DATA_SEL = 1
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic              rd,
  input  logic              wr,
  input  cons_flags_t       flags,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              data_rd,
  output logic              data_wr,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [SEL_W-1:0] STAT_CODE = SEL_W'(STAT_SEL);
  localparam logic [SEL_W-1:0] DATA_CODE = SEL_W'(DATA_SEL);

  assign data_rd = rd && (sel == DATA_CODE);
  // A write to the status address decodes to nothing at all.
  assign data_wr = wr && (sel == DATA_CODE);

  always_comb begin
    rdata = '0;
    if (data_rd) begin
      rdata = rx_byte;
    end else if (rd && (sel == STAT_CODE)) begin
      rdata[FLAG_W-1:0] = flags;
    end
  end
endmodule

// File: rtl/cons_sr_port.sv
module cons_sr_port
  import cons_port_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned STAT_SEL = 0,
  parameter int unsigned DATA_SEL = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  core_sel,
  input  logic              core_rd,
  input  logic              core_wr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic [DATA_W-1:0] core_rdata,
  output logic [DATA_W-1:0] out_byte,
  output logic              out_valid,
  input  logic              out_ready,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [FLAG_W-1:0] host_flags
);
  cons_flags_t       flags;
  logic              data_rd;
  logic              data_wr;
  logic [DATA_W-1:0] rx_byte;

  cons_reg_decode #(
    .DATA_W  (DATA_W),
    .SEL_W   (SEL_W),
    .STAT_SEL(STAT_SEL),
    .DATA_SEL(DATA_SEL)
  ) u_decode (
    .sel    (core_sel),
    .rd     (core_rd),
    .wr     (core_wr),
    .flags  (flags),
    .rx_byte(rx_byte),
    .data_rd(data_rd),
    .data_wr(data_wr),
    .rdata  (core_rdata)
  );

  cons_rx_slot #(.DATA_W(DATA_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_byte (in_byte),
    .in_ready(in_ready),
    .drain   (data_rd),
    .full    (flags.rx_full),
    .held    (rx_byte)
  );

  cons_tx_slot #(.DATA_W(DATA_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (data_wr),
    .wr_byte (core_wdata),
    .out_take(out_ready),
    .busy    (flags.tx_busy),
    .held    (out_byte)
  );

  assign out_valid  = flags.tx_busy;
  assign host_flags = flags;

  // R2: a status read shows both slot flags at their fixed bit positions.
  a_r2_status_view: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rd && core_sel == SEL_W'(STAT_SEL)) |->
      (core_rdata[RX_FLAG_BIT] == u_rx.full && core_rdata[TX_FLAG_BIT] == u_tx.busy));

  // R10: a status write leaves the transmit slot untouched.
  a_r10_status_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr && core_sel == SEL_W'(STAT_SEL) && !out_ready) |=>
      ($stable(out_byte) && $stable(out_valid)));
endmodule

// File: tb/test_cons_sr_port.sv
`timescale 1ns/1ps
module test_cons_sr_port;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    core_sel = '0;
  logic          core_rd = 1'b0, core_wr = 1'b0;
  logic [DW-1:0] core_wdata = '0;
  logic [DW-1:0] core_rdata;
  logic [DW-1:0] out_byte;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] in_byte = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    host_flags;

  always #2.5 clk = ~clk;

  cons_sr_port i_cons_sr_port (
    .clk(clk), .rst_n(rst_n), .core_sel(core_sel), .core_rd(core_rd),
    .core_wr(core_wr), .core_wdata(core_wdata), .core_rdata(core_rdata),
    .out_byte(out_byte), .out_valid(out_valid), .out_ready(out_ready),
    .in_byte(in_byte), .in_valid(in_valid), .in_ready(in_ready),
    .host_flags(host_flags)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // Behavioural model state.
  bit m_full = 0, m_busy = 0;
  int m_rx = 0, m_tx = 0;
  int txq[$];
  int rxq[$];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic state_chk(string tag);
    chk(tag, out_valid, m_busy);
    chk(tag, out_byte, m_tx);
    chk(tag, host_flags, {m_busy, m_full});
  endtask

  // Called at a negedge: drives one cycle, checks combinational outputs,
  // advances the model across the edge, then checks registered state.
  task automatic cyc(string tag, int sel, bit rd, bit wr, int wd,
                     bit take, bit dv, int db);
    bit drd, acc_wr, acc_in;
    int exp_rd;
    core_sel = 2'(sel); core_rd = rd; core_wr = wr; core_wdata = DW'(wd);
    out_ready = take; in_valid = dv; in_byte = DW'(db);
    #1;
    drd = rd && sel == 1;
    exp_rd = 0;
    if (drd) exp_rd = m_rx;
    else if (rd && sel == 0) exp_rd = {m_busy, m_full};
    chk(drd ? "R8" : (rd && sel == 0) ? "R2" : "R10", core_rdata, exp_rd);
    chk("R6", in_ready, (!m_full || drd) ? 1 : 0);
    // R11 scoreboard on both directions.
    if (take && m_busy) begin
      if (txq.size() == 0) chk("R11", out_byte, -1);
      else chk("R11", out_byte, txq.pop_front());
    end
    if (drd && m_full) begin
      if (rxq.size() == 0) chk("R11", core_rdata, -1);
      else chk("R11", core_rdata, rxq.pop_front());
    end
    acc_wr = wr && sel == 1 && !m_busy;
    acc_in = dv && (!m_full || drd);
    if (acc_wr) begin m_busy = 1; m_tx = wd & 8'hFF; txq.push_back(m_tx); end
    else if (take) m_busy = 0;
    if (acc_in) begin m_full = 1; m_rx = db & 8'hFF; rxq.push_back(m_rx); end
    else if (drd) m_full = 0;
    @(negedge clk);
    state_chk(tag);
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    state_chk("R1");
    cyc("R1", 1, 1, 0, 0, 0, 0, 0);          // R1: data read after reset is 0
    cyc("R2", 0, 1, 0, 0, 0, 0, 0);          // R2: idle status
    cyc("R3", 1, 0, 1, 'hA5, 0, 0, 0);       // R3: write into empty slot
    cyc("R4", 1, 0, 1, 'h3C, 0, 0, 0);       // R4: write while busy ignored
    cyc("R2", 0, 1, 0, 0, 0, 0, 0);          // R2: status shows tx busy
    cyc("R10", 0, 0, 1, 'hFF, 0, 0, 0);      // R10: status write inert
    cyc("R5", 0, 0, 0, 0, 1, 0, 0);          // R5: host takes byte
    cyc("R5", 0, 0, 0, 0, 1, 0, 0);          // R5: take with nothing pending
    cyc("R6", 0, 0, 0, 0, 0, 1, 'h5A);       // R6: delivery into empty slot
    cyc("R7", 0, 0, 0, 0, 0, 1, 'h77);       // R7: delivery while full ignored
    cyc("R10", 2, 1, 0, 0, 0, 0, 0);         // R10: unused address reads 0
    cyc("R10", 3, 1, 1, 'h12, 0, 0, 0);      // R10: unused address write
    cyc("R10", 1, 0, 0, 0, 0, 0, 0);         // R10: rd low gives 0
    cyc("R8", 1, 1, 0, 0, 0, 0, 0);          // R8: read returns 5A, clears
    cyc("R6", 0, 0, 0, 0, 0, 1, 'h11);
    cyc("R9", 1, 1, 0, 0, 0, 1, 'h22);       // R9: read and delivery together
    cyc("R9", 1, 1, 0, 0, 0, 0, 0);          // R9: new byte is readable
    // Host disconnected: first write lands, later writes are held off.
    cyc("R4", 1, 0, 1, 'h01, 0, 0, 0);
    for (int k = 0; k < 4; k++) cyc("R4", 1, 0, 1, k + 2, 0, 0, 0);
    cyc("R5", 0, 0, 0, 0, 1, 0, 0);
    // Random back-to-back traffic in both directions.
    for (int n = 0; n < 4000; n++) begin
      int sel = $urandom_range(0, 3);
      if ($urandom_range(0, 3) != 0) sel = 1;
      cyc("R11", sel, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          int'($urandom_range(0, 255)),
          (n / 500) % 2 == 1 ? 1'b0 : 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), int'($urandom_range(0, 255)));
    end
    idle("R11");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule